// File: doc/BRIEF.md
# Configurable I/O Cell Logic

This block is the digital logic of a programmable pad cell, replicated across a small group of pads that share one configuration. On the receive side it takes the pad value and produces two fabric-facing signals. Each of them can show either the raw pad value or a stored copy. The storage element is built as a rising-edge flip-flop or as a level-sensitive latch, and its clock can be inverted.

On the transmit side, fabric data reaches the pad either directly or through an output flip-flop. That flip-flop has its own clock, its own clock enable and an optional clock inversion. The pad output-enable is active when the fabric's three-state control is low. A global three-state input overrides it.

A global set/reset loads both storage elements with configured start values. It acts asynchronously. All configuration inputs are static bits that are expected to change only while the global set/reset is asserted.

Top module: `iocell`

## Requirements
- R1: With `cfg_in_latch`=0 and `cfg_in_clk_inv`=0, the input store captures `pad_in` on the rising edge of `clk_in` when `in_ce`=1.
- R2: With `cfg_in_latch`=1, the input store is transparent while its effective clock is high and `in_ce`=1. It holds its value otherwise.
- R3: With `cfg_in_clk_inv`=1, the effective input clock is `clk_in` inverted. The flip-flop then captures on the falling edge of `clk_in`, and the latch is transparent while `clk_in` is low.
- R4: `fab_i1` and `fab_i2` each select independently. With `cfg_i1_stored`/`cfg_i2_stored`=0 the line shows `pad_in` directly. With 1 it shows the input store.
- R5: While `in_ce`=0, the input store keeps its value whatever `pad_in` does.
- R6: With `cfg_out_reg`=0, `pad_out` follows `fab_o` directly. With 1, `pad_out` shows an output flip-flop that captures `fab_o` on the rising edge of `clk_out`, or on the falling edge when `cfg_out_clk_inv`=1.
- R7: While `out_ce`=0, the output flip-flop keeps its value.
- R8: Each bit of `pad_oe` is 1 exactly when its `fab_t` bit is 0 and `gts` is 0. `gts`=1 forces every bit to 0.
- R9: While `gsr`=1, the input store holds `cfg_in_init` and the output flip-flop holds `cfg_out_init`. This takes effect within the same cycle, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input-store clock |
| clk_out | input | 1 | Output flip-flop clock |
| gsr | input | 1 | Global asynchronous set/reset, active high |
| gts | input | 1 | Global three-state, active high |
| cfg_in_latch | input | 1 | 0: input store is a flip-flop, 1: a latch |
| cfg_in_clk_inv | input | 1 | Invert the input-store clock |
| cfg_i1_stored | input | 1 | fab_i1 source: 0 direct, 1 stored |
| cfg_i2_stored | input | 1 | fab_i2 source: 0 direct, 1 stored |
| cfg_out_reg | input | 1 | 0: pad_out direct, 1: registered |
| cfg_out_clk_inv | input | 1 | Invert the output flip-flop clock |
| cfg_in_init | input | W | Input-store value under gsr |
| cfg_out_init | input | W | Output flip-flop value under gsr |
| pad_in | input | W | Value received from the pads |
| in_ce | input | 1 | Input-store clock enable |
| fab_i1 | output | W | First fabric receive line |
| fab_i2 | output | W | Second fabric receive line |
| fab_o | input | W | Transmit data from the fabric |
| fab_t | input | W | Three-state control from the fabric, 1 = float |
| out_ce | input | 1 | Output flip-flop clock enable |
| pad_out | output | W | Value driven toward the pads |
| pad_oe | output | W | Pad output-enable, 1 = drive |

## Verification
Direct receive lines, direct `pad_out` and `pad_oe` are due in the same cycle as the stimulus. So are the latch, falling-edge flip-flop and `gsr` results, since each settles before the following rising edge. Rising-edge flip-flop results are due one cycle later, because they show the data of the previous cycle.

The bench's reference model keeps the previous cycle's data and enable to cover that lag. Stimulus changes 1 ns after a rising edge, and every expectation is compared 2 ns before the next one. This keeps each check clear of both clock edges in every clock-inversion setting.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

    typedef enum logic {
        STORE_FLOP  = 1'b0,
        STORE_LATCH = 1'b1
    } store_mode_e;

    typedef enum logic {
        TAP_DIRECT = 1'b0,
        TAP_STORED = 1'b1
    } tap_sel_e;

    typedef enum logic {
        DRV_DIRECT = 1'b0,
        DRV_REG    = 1'b1
    } drv_mode_e;

endpackage

// File: rtl/iocell_in_store.sv
module iocell_in_store
    import iocell_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         gsr,
    input  logic         clk_inv,
    input  logic         latch_mode,
    input  logic         ce,
    input  logic [W-1:0] d,
    input  logic [W-1:0] init,
    output logic [W-1:0] q
);

    logic         clk_eff;
    logic [W-1:0] q_ff;
    logic [W-1:0] q_lat;
    store_mode_e  mode;

    assign clk_eff = clk ^ clk_inv;
    assign mode    = store_mode_e'(latch_mode);

    // edge-triggered variant
    always_ff @(posedge clk_eff or posedge gsr) begin
        if (gsr) begin
            q_ff <= init;
        end else if (ce) begin
            q_ff <= d;
        end
    end

    // level-sensitive variant, open while the effective clock is high
    always_latch begin
        if (gsr) begin
            q_lat <= init;
        end else if (clk_eff && ce) begin
            q_lat <= d;
        end
    end

    always_comb begin
        unique case (mode)
            STORE_FLOP:  q = q_ff;
            STORE_LATCH: q = q_lat;
        endcase
    end

    // R1 / R3: enabled edge loads the data seen at that edge
    a_r1_flop_capture: assert property (@(posedge clk_eff) disable iff (gsr)
        ce |=> (q_ff == $past(d)));

    // R5: disabled edge keeps the stored value
    a_r5_flop_hold: assert property (@(posedge clk_eff) disable iff (gsr)
        !ce |=> $stable(q_ff));

    // R2: at the closing edge the latch shows the data it was following
    a_r2_latch_follow: assert property (@(negedge clk_eff) disable iff (gsr)
        ce |-> (q_lat == d));

endmodule

// File: rtl/iocell_tap.sv
module iocell_tap
    import iocell_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         sel,
    input  logic [W-1:0] direct,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    tap_sel_e src;
    assign src = tap_sel_e'(sel);

    always_comb begin
        unique case (src)
            TAP_DIRECT: y = direct;
            TAP_STORED: y = stored;
        endcase
    end

endmodule

// File: rtl/iocell_out_path.sv
module iocell_out_path
    import iocell_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         gsr,
    input  logic         clk_inv,
    input  logic         use_reg,
    input  logic         ce,
    input  logic [W-1:0] o,
    input  logic [W-1:0] init,
    output logic [W-1:0] pad_out
);

    logic         clk_eff;
    logic [W-1:0] q_o;
    drv_mode_e    mode;

    assign clk_eff = clk ^ clk_inv;
    assign mode    = drv_mode_e'(use_reg);

    always_ff @(posedge clk_eff or posedge gsr) begin
        if (gsr) begin
            q_o <= init;
        end else if (ce) begin
            q_o <= o;
        end
    end

    always_comb begin
        unique case (mode)
            DRV_DIRECT: pad_out = o;
            DRV_REG:    pad_out = q_o;
        endcase
    end

    // R6: enabled edge loads the fabric data
    a_r6_out_capture: assert property (@(posedge clk_eff) disable iff (gsr)
        ce |=> (q_o == $past(o)));

    // R7: disabled edge keeps the output register
    a_r7_out_hold: assert property (@(posedge clk_eff) disable iff (gsr)
        !ce |=> $stable(q_o));

endmodule

// File: rtl/iocell.sv
module iocell
    import iocell_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk_in,
    input  logic         clk_out,
    input  logic         gsr,
    input  logic         gts,
    input  logic         cfg_in_latch,
    input  logic         cfg_in_clk_inv,
    input  logic         cfg_i1_stored,
    input  logic         cfg_i2_stored,
    input  logic         cfg_out_reg,
    input  logic         cfg_out_clk_inv,
    input  logic [W-1:0] cfg_in_init,
    input  logic [W-1:0] cfg_out_init,
    input  logic [W-1:0] pad_in,
    input  logic         in_ce,
    output logic [W-1:0] fab_i1,
    output logic [W-1:0] fab_i2,
    input  logic [W-1:0] fab_o,
    input  logic [W-1:0] fab_t,
    input  logic         out_ce,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    localparam int NTAP = 2;

    logic [W-1:0]    stored;
    logic [NTAP-1:0] tap_sel;
    logic [W-1:0]    tap_y [NTAP];

    assign tap_sel = {cfg_i2_stored, cfg_i1_stored};

    iocell_in_store #(.W(W)) u_in_store (
        .clk        (clk_in),
        .gsr        (gsr),
        .clk_inv    (cfg_in_clk_inv),
        .latch_mode (cfg_in_latch),
        .ce         (in_ce),
        .d          (pad_in),
        .init       (cfg_in_init),
        .q          (stored)
    );

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        iocell_tap #(.W(W)) u_tap (
            .sel    (tap_sel[g]),
            .direct (pad_in),
            .stored (stored),
            .y      (tap_y[g])
        );
    end

    assign fab_i1 = tap_y[0];
    assign fab_i2 = tap_y[1];

    iocell_out_path #(.W(W)) u_out_path (
        .clk     (clk_out),
        .gsr     (gsr),
        .clk_inv (cfg_out_clk_inv),
        .use_reg (cfg_out_reg),
        .ce      (out_ce),
        .o       (fab_o),
        .init    (cfg_out_init),
        .pad_out (pad_out)
    );

    assign pad_oe = ~fab_t & {W{~gts}};

    // R8: global three-state leaves no pad driven
    a_r8_gts_blocks: assert property (@(posedge clk_out) disable iff (gsr)
        gts |-> (pad_oe == '0));

endmodule

// File: tb/iocell_bench.sv
module iocell_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         gsr = 1'b1;
    logic         gts = 1'b0;
    logic         cfg_in_latch = 1'b0, cfg_in_clk_inv = 1'b0;
    logic         cfg_i1_stored = 1'b0, cfg_i2_stored = 1'b0;
    logic         cfg_out_reg = 1'b0, cfg_out_clk_inv = 1'b0;
    logic [W-1:0] cfg_in_init = '0, cfg_out_init = '0;
    logic [W-1:0] pad_in = '0, fab_o = '0, fab_t = '0;
    logic         in_ce = 1'b0, out_ce = 1'b0;
    logic [W-1:0] fab_i1, fab_i2, pad_out, pad_oe;

    always #5 clk = ~clk;

    iocell #(.W(W)) u_iocell (
        .clk_in          (clk),
        .clk_out         (clk),
        .gsr             (gsr),
        .gts             (gts),
        .cfg_in_latch    (cfg_in_latch),
        .cfg_in_clk_inv  (cfg_in_clk_inv),
        .cfg_i1_stored   (cfg_i1_stored),
        .cfg_i2_stored   (cfg_i2_stored),
        .cfg_out_reg     (cfg_out_reg),
        .cfg_out_clk_inv (cfg_out_clk_inv),
        .cfg_in_init     (cfg_in_init),
        .cfg_out_init    (cfg_out_init),
        .pad_in          (pad_in),
        .in_ce           (in_ce),
        .fab_i1          (fab_i1),
        .fab_i2          (fab_i2),
        .fab_o           (fab_o),
        .fab_t           (fab_t),
        .out_ce          (out_ce),
        .pad_out         (pad_out),
        .pad_oe          (pad_oe)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // scoreboard: 0 fab_i1, 1 fab_i2, 2 pad_out, 3 pad_oe
    string        sb_req [$];
    int           sb_sig [$];
    logic [W-1:0] sb_exp [$];

    // reference model state
    logic [W-1:0] m_st, m_prev_d, m_ost, m_prev_o;
    logic         m_prev_ce, m_prev_oce;

    function automatic logic [W-1:0] actual(int sig);
        case (sig)
            0:       return fab_i1;
            1:       return fab_i2;
            2:       return pad_out;
            default: return pad_oe;
        endcase
    endfunction

    task automatic push(string req, int sig, logic [W-1:0] exp);
        sb_req.push_back(req);
        sb_sig.push_back(sig);
        sb_exp.push_back(exp);
    endtask

    // monitor: compares 2 ns before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb_sig.size() > 0) begin
                string        r;
                int           s;
                logic [W-1:0] e;
                logic [W-1:0] a;
                r = sb_req.pop_front();
                s = sb_sig.pop_front();
                e = sb_exp.pop_front();
                a = actual(s);
                checks++;
                if (a !== e) begin
                    failures++;
                    $display("FAIL %s sig=%0d t=%0t actual=%h expected=%h", r, s, $time, a, e);
                end
            end
        end
    end

    task automatic push_all(string tag_in, string tag_out, logic [W-1:0] d,
                            logic [W-1:0] o, logic [W-1:0] t, logic g);
        push(cfg_i1_stored ? tag_in : "R4", 0, cfg_i1_stored ? m_st : d);
        push(cfg_i2_stored ? tag_in : "R4", 1, cfg_i2_stored ? m_st : d);
        push(tag_out, 2, cfg_out_reg ? m_ost : o);
        push("R8", 3, ~t & {W{~g}});
    endtask

    // R9: configure under global set/reset, checked in the same cycle
    task automatic configure(logic [5:0] c);
        logic [W-1:0] ii;
        logic [W-1:0] oi;
        ii = c[0] ? 4'h5 : 4'hC;
        oi = c[1] ? 4'h9 : 4'h6;
        @(posedge clk);
        #1;
        gsr = 1'b1;
        in_ce = 1'b0;
        out_ce = 1'b0;
        {cfg_out_clk_inv, cfg_out_reg, cfg_i2_stored, cfg_i1_stored,
         cfg_in_clk_inv, cfg_in_latch} = c;
        cfg_in_init = ii;
        cfg_out_init = oi;
        pad_in = 4'h3;
        fab_o = 4'hA;
        fab_t = 4'h0;
        gts = 1'b0;
        m_st = ii;
        m_ost = oi;
        m_prev_ce = 1'b0;
        m_prev_oce = 1'b0;
        m_prev_d = pad_in;
        m_prev_o = fab_o;
        push_all("R9", "R9", pad_in, fab_o, fab_t, gts);
        @(posedge clk);
        #1;
        gsr = 1'b0;
        push_all("R9", "R9", pad_in, fab_o, fab_t, gts);
    endtask

    task automatic step(logic [W-1:0] d, logic ce, logic [W-1:0] o, logic oce,
                        logic [W-1:0] t, logic g);
        string ti;
        string to;
        @(posedge clk);
        #1;
        pad_in = d;
        in_ce = ce;
        fab_o = o;
        out_ce = oce;
        fab_t = t;
        gts = g;
        // R1 rising flop lags one cycle; R2/R3 latch and falling flop settle this cycle
        if (cfg_in_latch || cfg_in_clk_inv) begin
            if (ce) m_st = d;
        end else begin
            if (m_prev_ce) m_st = m_prev_d;
        end
        if (cfg_out_clk_inv) begin
            if (oce) m_ost = o;
        end else begin
            if (m_prev_oce) m_ost = m_prev_o;
        end
        m_prev_d = d;
        m_prev_ce = ce;
        m_prev_o = o;
        m_prev_oce = oce;
        ti = !ce ? "R5" : cfg_in_latch ? "R2" : cfg_in_clk_inv ? "R3" : "R1";
        to = (cfg_out_reg && !oce) ? "R7" : "R6";
        push_all(ti, to, d, o, t, g);
    endtask

    initial begin
        for (int c = 0; c < 64; c++) begin
            configure(6'(c));
            for (int k = 0; k < 9; k++) begin
                logic [W-1:0] d;
                d = 4'((k * 7 + c * 3 + 1) & 15);
                step(d, (k != 3 && k != 4), ~d ^ 4'(k), (k != 5 && k != 6),
                     4'(k * 5), (k == 6));
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 100000 && !done; n++) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule